// File: doc/BRIEF.md
# Dual-Rate Pseudo-Noise Sliding Correlator

This core is the digital baseband of a channel sounder. It can act as either end of a link, and a single mode input selects which. It contains two maximal-length linear feedback shift registers. Each has a programmable active length N and its own feedback tap mask. Each is advanced by a clock-enable strobe that is derived from the one system clock. The first generator ("fast") steps once every `per_a` system cycles. The second generator ("slow") steps once every `per_b` cycles, with `per_b` chosen larger than `per_a`.

In transmit mode the core emits the fast generator's chip stream, and the slow generator and the correlators stay idle. In receive mode the core does three things:
- It emits the chip product of the two generators as a reference stream.
- It pulses a sync flag whenever both generators return to their seed state together. This gives a zero-delay timing mark.
- It correlates signed I and Q samples against the slow replica. Windowed accumulators collect the products and deliver a time-dilated correlation result. The peaks of that result recur dilated by the factor per_b / (per_b − per_a) in chip terms.

A configuration write latches all settings at once. The following cycle restarts both generators, both strobes and both accumulators.

Top module: `pn_slide_corr`

## Requirements
- R1: With `mode_rx` low (transmit), `sync_out`, `ref_out` and `corr_valid` stay 0, and the slow generator holds its state. With `mode_rx` high (receive), `chip_out` still carries the fast generator.
- R2: Each generator holds an N-bit state, and its seed is all ones in bits N-1..0. A step shifts the state left by one and puts the parity of (state AND taps) into bit 0. The output chip is bit N-1. Chip bit 0 stands for +1 and chip bit 1 stands for −1.
- R3: The fast generator steps once every `per_a` system cycles, and `chip_out` is constant between steps. A period of 0 acts as 1.
- R4: Primitive taps give a sequence period of 2^N−1 chips, with 2^(N−1) ones per period. Examples are N=4 with taps 0x00C, and N=5 with taps 0x014.
- R5: A generator never holds the all-zero state. A step that would produce zero loads the seed instead.
- R6: After reset, or one cycle after a configuration write, both generators are at their seed. At that point the strobe counters and the accumulators are cleared, and `corr_valid` is 0.
- R7: In receive mode `sync_out` is a one-cycle pulse in any cycle where both generators are at seed and they were not both at seed in the previous cycle. The first pulse comes right after a restart. Later pulses follow at the least common multiple of the two sequence periods in system cycles.
- R8: In receive mode each accumulator adds +sample or −sample every system cycle. The sign is + for a slow chip of 0 and − for a slow chip of 1. After `win` cycles the sum, including that cycle's term, goes to `corr_i`/`corr_q`, `corr_valid` pulses for one cycle, and the accumulator restarts from zero.
- R9: In receive mode the slow generator steps once every `per_b` system cycles.
- R10: `ref_out` in receive mode equals the XOR of the fast chip and the slow chip.
- R11: The most negative sample (−128) is negated exactly, so a negative chip turns it into +128 with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Latch all configuration inputs and restart |
| cfg_len | input | 5 | Active LFSR length N |
| cfg_taps_a | input | 16 | Fast generator tap mask |
| cfg_taps_b | input | 16 | Slow generator tap mask |
| cfg_per_a | input | 12 | Fast strobe period in cycles |
| cfg_per_b | input | 12 | Slow strobe period in cycles |
| cfg_win | input | 16 | Correlation window in cycles |
| mode_rx | input | 1 | 0 transmit, 1 receive |
| samp_i | input | 8 | Signed in-phase sample |
| samp_q | input | 8 | Signed quadrature sample |
| chip_out | output | 1 | Fast generator chip |
| sync_out | output | 1 | Coincident-seed pulse |
| ref_out | output | 1 | Product of fast and slow chips |
| corr_i | output | 25 | Signed I correlation result |
| corr_q | output | 25 | Signed Q correlation result |
| corr_valid | output | 1 | Result strobe |

## Verification
The correlators are driven with constant I/Q values over windows that span whole periods of the slow sequence. Such a window must return exactly −1, −2 or −3 times the sample, depending on the slow rate. This shows whether the chip sign is mapped correctly and whether the window boundaries are correct. A one-cycle window with a fixed sample exposes every slow chip in turn. −128 and +127 probe the extremes of negation. Two rate pairs are used. Equal rates with zero taps exercise the zero-state recovery through the sync period. Rates 2 and 3 separate the lcm-based sync spacing and the reference product from a model that ignores one of the strobes.

// File: rtl/pn_slide_pkg.sv
`timescale 1ns/1ps
package pn_slide_pkg;

    localparam int PN_W   = 16;
    localparam int PER_W  = 12;
    localparam int WIN_W  = 16;
    localparam int SAMP_W = 8;

    localparam int DEF_LEN  = 4;
    localparam int DEF_TAPS = 12;
    localparam int DEF_PERA = 1;
    localparam int DEF_PERB = 2;
    localparam int DEF_WIN  = 15;

    typedef enum logic {
        SND_TX = 1'b0,
        SND_RX = 1'b1
    } snd_mode_e;

    // product of two antipodal chips encoded 0 -> +1, 1 -> -1
    function automatic logic chip_mul(input logic a, input logic b);
        return a ^ b;
    endfunction

endpackage

// File: rtl/pn_rate_strobe.sv
`timescale 1ns/1ps
module pn_rate_strobe #(
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          en,
    input  logic [PW-1:0] period,
    output logic          tick
);
    logic [PW-1:0] cnt;
    logic [PW-1:0] last;

    assign last = (period == '0) ? '0 : period - PW'(1);
    assign tick = en && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (en)
            cnt <= tick ? '0 : cnt + PW'(1);
    end
endmodule

// File: rtl/pn_lfsr.sv
`timescale 1ns/1ps
module pn_lfsr #(
    parameter int NMAX = 16,
    parameter int LW   = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    input  logic [LW-1:0]   len,
    input  logic [NMAX-1:0] taps,
    output logic [NMAX-1:0] state,
    output logic            chip,
    output logic            at_seed
);
    logic [NMAX-1:0] mask;
    logic [NMAX-1:0] shifted;
    logic [NMAX-1:0] nxt;
    logic            fb;

    always_comb begin
        mask = '0;
        chip = 1'b0;
        for (int i = 0; i < NMAX; i++) begin
            mask[i] = (LW'(i) < len);
            if (LW'(i + 1) == len)
                chip = state[i];
        end
        fb      = ^(state & taps & mask);
        shifted = {state[NMAX-2:0], fb} & mask;
        nxt     = (shifted == '0) ? mask : shifted;
    end

    assign at_seed = (state == mask);

    always_ff @(posedge clk) begin
        if (rst)
            state <= '1;
        else if (load)
            state <= mask;
        else if (step)
            state <= nxt;
    end
endmodule

// File: rtl/pn_corr_acc.sv
`timescale 1ns/1ps
module pn_corr_acc #(
    parameter int SW = 8,
    parameter int WW = 16,
    localparam int AW = SW + WW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 en,
    input  logic                 chip,
    input  logic signed [SW-1:0] samp,
    input  logic [WW-1:0]        win,
    output logic signed [AW-1:0] corr,
    output logic                 valid
);
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] ext;
    logic signed [AW-1:0] term;
    logic [WW-1:0]        wcnt;
    logic [WW-1:0]        wlast_val;
    logic                 wlast;

    assign ext       = AW'(samp);
    assign term      = chip ? -ext : ext;
    assign wlast_val = (win == '0) ? '0 : win - WW'(1);
    assign wlast     = en && (wcnt == wlast_val);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc   <= '0;
            wcnt  <= '0;
            corr  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= wlast;
            if (en) begin
                wcnt <= wlast ? '0 : wcnt + WW'(1);
                acc  <= wlast ? '0 : acc + term;
            end
            if (wlast)
                corr <= acc + term;
        end
    end
endmodule

// File: rtl/pn_slide_corr.sv
`timescale 1ns/1ps
module pn_slide_corr
    import pn_slide_pkg::*;
#(
    parameter int NMAX = PN_W,
    parameter int PW   = PER_W,
    parameter int WW   = WIN_W,
    parameter int SW   = SAMP_W,
    localparam int LW  = $clog2(NMAX + 1),
    localparam int AW  = SW + WW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [LW-1:0]        cfg_len,
    input  logic [NMAX-1:0]      cfg_taps_a,
    input  logic [NMAX-1:0]      cfg_taps_b,
    input  logic [PW-1:0]        cfg_per_a,
    input  logic [PW-1:0]        cfg_per_b,
    input  logic [WW-1:0]        cfg_win,
    input  logic                 mode_rx,
    input  logic signed [SW-1:0] samp_i,
    input  logic signed [SW-1:0] samp_q,
    output logic                 chip_out,
    output logic                 sync_out,
    output logic                 ref_out,
    output logic signed [AW-1:0] corr_i,
    output logic signed [AW-1:0] corr_q,
    output logic                 corr_valid
);
    typedef struct packed {
        logic [LW-1:0]   len;
        logic [NMAX-1:0] taps_a;
        logic [NMAX-1:0] taps_b;
        logic [PW-1:0]   per_a;
        logic [PW-1:0]   per_b;
        logic [WW-1:0]   win;
    } snd_cfg_t;

    snd_cfg_t        cfg_q;
    snd_mode_e       mode;
    logic            rx;
    logic            restart_q;
    logic            tick_a, tick_b;
    logic            chip_a, chip_b;
    logic            seed_a, seed_b;
    logic            both_q;
    logic [NMAX-1:0] lfsr_a_st, lfsr_b_st;

    assign mode = snd_mode_e'(mode_rx);
    assign rx   = (mode == SND_RX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '{len: LW'(DEF_LEN), taps_a: NMAX'(DEF_TAPS), taps_b: NMAX'(DEF_TAPS),
                           per_a: PW'(DEF_PERA), per_b: PW'(DEF_PERB), win: WW'(DEF_WIN)};
            restart_q <= 1'b1;
        end else begin
            if (cfg_we)
                cfg_q <= '{len: cfg_len, taps_a: cfg_taps_a, taps_b: cfg_taps_b,
                           per_a: cfg_per_a, per_b: cfg_per_b, win: cfg_win};
            restart_q <= cfg_we;
        end
    end

    pn_rate_strobe #(.PW(PW)) u_stb_a (
        .clk(clk), .rst(rst), .restart(restart_q), .en(!restart_q),
        .period(cfg_q.per_a), .tick(tick_a));

    pn_rate_strobe #(.PW(PW)) u_stb_b (
        .clk(clk), .rst(rst), .restart(restart_q), .en(rx && !restart_q),
        .period(cfg_q.per_b), .tick(tick_b));

    pn_lfsr #(.NMAX(NMAX), .LW(LW)) u_gen_a (
        .clk(clk), .rst(rst), .load(restart_q), .step(tick_a),
        .len(cfg_q.len), .taps(cfg_q.taps_a),
        .state(lfsr_a_st), .chip(chip_a), .at_seed(seed_a));

    pn_lfsr #(.NMAX(NMAX), .LW(LW)) u_gen_b (
        .clk(clk), .rst(rst), .load(restart_q), .step(tick_b),
        .len(cfg_q.len), .taps(cfg_q.taps_b),
        .state(lfsr_b_st), .chip(chip_b), .at_seed(seed_b));

    always_ff @(posedge clk) begin
        if (rst || restart_q)
            both_q <= 1'b0;
        else
            both_q <= seed_a && seed_b;
    end

    assign chip_out = chip_a;
    assign sync_out = rx && !restart_q && seed_a && seed_b && !both_q;
    assign ref_out  = rx && chip_mul(chip_a, chip_b);

    logic signed [SW-1:0] ch_in  [2];
    logic signed [AW-1:0] ch_out [2];
    logic [1:0]           ch_vld;

    assign ch_in[0] = samp_i;
    assign ch_in[1] = samp_q;

    for (genvar c = 0; c < 2; c++) begin : g_acc
        pn_corr_acc #(.SW(SW), .WW(WW)) u_acc (
            .clk(clk), .rst(rst), .clear(restart_q), .en(rx && !restart_q),
            .chip(chip_b), .samp(ch_in[c]), .win(cfg_q.win),
            .corr(ch_out[c]), .valid(ch_vld[c]));
    end

    assign corr_i     = ch_out[0];
    assign corr_q     = ch_out[1];
    assign corr_valid = &ch_vld;
endmodule

// File: rtl/pn_slide_corr_chk.sv
`timescale 1ns/1ps
module pn_slide_corr_chk #(
    parameter int NMAX = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            cfg_we,
    input logic            mode_rx,
    input logic            restart_q,
    input logic            tick_a,
    input logic            chip_out,
    input logic            sync_out,
    input logic            ref_out,
    input logic            corr_valid,
    input logic [NMAX-1:0] st_a,
    input logic [NMAX-1:0] st_b
);
    // R5
    gen_a_nonzero_chk: assert property (@(posedge clk) disable iff (rst) st_a != '0);
    // R5
    gen_b_nonzero_chk: assert property (@(posedge clk) disable iff (rst) st_b != '0);
    // R1
    tx_no_sync_chk: assert property (@(posedge clk) disable iff (rst) !mode_rx |-> !sync_out);
    // R1
    tx_no_ref_chk: assert property (@(posedge clk) disable iff (rst) !mode_rx |-> !ref_out);
    // R1
    tx_no_corr_chk: assert property (@(posedge clk) disable iff (rst) corr_valid |-> $past(mode_rx));
    // R1
    tx_hold_b_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_rx && !restart_q) |=> $stable(st_b));
    // R7
    sync_single_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_out && !cfg_we) |=> !sync_out);
    // R3
    chip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_a && !restart_q && !cfg_we) |=> $stable(chip_out));
endmodule

bind pn_slide_corr pn_slide_corr_chk #(.NMAX(NMAX)) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .mode_rx(mode_rx),
    .restart_q(restart_q), .tick_a(tick_a), .chip_out(chip_out),
    .sync_out(sync_out), .ref_out(ref_out), .corr_valid(corr_valid),
    .st_a(lfsr_a_st), .st_b(lfsr_b_st));

// File: tb/pn_slide_corr_tb.sv
`timescale 1ns/1ps
module pn_slide_corr_tb;
    localparam int AW = 25;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_len = '0;
    logic [15:0] cfg_taps_a = '0, cfg_taps_b = '0;
    logic [11:0] cfg_per_a = '0, cfg_per_b = '0;
    logic [15:0] cfg_win = '0;
    logic        mode_rx = 1'b0;
    logic signed [7:0] samp_i = '0, samp_q = '0;
    logic chip_out, sync_out, ref_out, corr_valid;
    logic signed [AW-1:0] corr_i, corr_q;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    pn_slide_corr u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_len(cfg_len),
        .cfg_taps_a(cfg_taps_a), .cfg_taps_b(cfg_taps_b),
        .cfg_per_a(cfg_per_a), .cfg_per_b(cfg_per_b), .cfg_win(cfg_win),
        .mode_rx(mode_rx), .samp_i(samp_i), .samp_q(samp_q),
        .chip_out(chip_out), .sync_out(sync_out), .ref_out(ref_out),
        .corr_i(corr_i), .corr_q(corr_q), .corr_valid(corr_valid));

    // len, taps, per_b, win, I, Q, expected I, expected Q
    localparam int VEC [5][8] = '{
        '{4, 12, 1, 15,    5,  -3,   -5,    3},
        '{4, 12, 1, 30,    7,   0,  -14,    0},
        '{4, 12, 2, 30, -128, 127,  256, -254},
        '{5, 20, 1, 31,   10, -10,  -10,   10},
        '{4, 12, 3, 45,    2,  -1,   -6,    3}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mstep(input logic [15:0] s, input logic [15:0] t, input int n);
        logic [15:0] m = 16'((32'd1 << n) - 1);
        logic fb = ^(s & t & m);
        logic [15:0] ns = ((s << 1) | 16'(fb)) & m;
        return (ns == 0) ? m : ns;
    endfunction

    function automatic logic mchip(input logic [15:0] s, input int n);
        return s[n-1];
    endfunction

    task automatic configure(input int len, input int ta, input int tb,
                             input int pa, input int pb, input int win);
        @(negedge clk);
        cfg_len = 5'(len); cfg_taps_a = 16'(ta); cfg_taps_b = 16'(tb);
        cfg_per_a = 12'(pa); cfg_per_b = 12'(pb); cfg_win = 16'(win);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic rec [30];
        logic [15:0] ma, mb;
        int miss, ones, hits;

        // reset state, R6
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(chip_out == 1'b1, "R6 reset seed chip", chip_out, 1);
        chk(sync_out == 1'b0 && corr_valid == 1'b0, "R6 reset outputs idle", sync_out + corr_valid, 0);
        chk(corr_i == 0 && corr_q == 0, "R6 reset results zero", int'(corr_i), 0);

        // transmit sequence, R2 R1
        mode_rx = 1'b0;
        configure(4, 12, 12, 1, 2, 15);
        ma = 16'hF; miss = 0;
        for (int k = 0; k < 30; k++) begin
            rec[k] = chip_out;
            chk(chip_out == mchip(ma, 4), "R2 tx chip", chip_out, mchip(ma, 4));
            if (sync_out || ref_out || corr_valid) miss++;
            ma = mstep(ma, 16'd12, 4);
            @(negedge clk);
        end
        chk(miss == 0, "R1 tx idle sync/ref/valid", miss, 0);

        // period, R4
        ones = 0; miss = 0;
        for (int k = 0; k < 15; k++) begin
            ones += int'(rec[k]);
            if (rec[k] != rec[k + 15]) miss++;
        end
        chk(ones == 8, "R4 ones per period", ones, 8);
        chk(miss == 0, "R4 period 15", miss, 0);

        // slow fast rate with N=5, R3 R4
        configure(5, 20, 20, 3, 4, 31);
        ma = 16'h1F; miss = 0; ones = 0;
        for (int k = 0; k < 93; k++) begin
            if (chip_out != mchip(ma, 5)) miss++;
            if (k % 3 == 0) ones += int'(chip_out);
            if (k % 3 == 2) ma = mstep(ma, 16'd20, 5);
            @(negedge clk);
        end
        chk(miss == 0, "R3 chip held per_a cycles", miss, 0);
        chk(ones == 16 && ma == 16'h1F, "R4 N=5 period 31", ones, 16);

        // correlation table, R8 R9 R11
        mode_rx = 1'b1;
        for (int v = 0; v < 5; v++) begin
            samp_i = 8'(VEC[v][4]);
            samp_q = 8'(VEC[v][5]);
            configure(VEC[v][0], VEC[v][1], VEC[v][1], 1, VEC[v][2], VEC[v][3]);
            for (int d = 0; d < 2; d++) begin
                hits = 0;
                for (int w = 0; w < 300 && !corr_valid; w++) @(negedge clk);
                if (corr_valid) hits = 1;
                chk(hits == 1, "R8 window dump seen", hits, 1);
                chk(int'(corr_i) == VEC[v][6], "R8 R9 R11 corr_i", int'(corr_i), VEC[v][6]);
                chk(int'(corr_q) == VEC[v][7], "R8 R9 R11 corr_q", int'(corr_q), VEC[v][7]);
                @(negedge clk);
            end
        end

        // one-cycle window exposes each slow chip, R8 R2
        samp_i = 8'sd9; samp_q = -8'sd4;
        configure(4, 12, 12, 1, 1, 1);
        @(negedge clk);
        mb = 16'hF; miss = 0;
        for (int k = 0; k < 20; k++) begin
            if (!corr_valid) miss++;
            if (int'(corr_i) != (mchip(mb, 4) ? -9 : 9)) miss++;
            if (int'(corr_q) != (mchip(mb, 4) ? 4 : -4)) miss++;
            mb = mstep(mb, 16'd12, 4);
            @(negedge clk);
        end
        chk(miss == 0, "R8 per-chip sign", miss, 0);

        // sync spacing and reference product, R7 R10 R9
        configure(4, 12, 12, 2, 3, 15);
        chk(sync_out == 1'b1, "R7 sync after restart", sync_out, 1);
        ma = 16'hF; mb = 16'hF; miss = 0; hits = 0;
        for (int j = 0; j < 181; j++) begin
            if (sync_out != (j % 90 == 0)) miss++;
            if (ref_out != (mchip(ma, 4) ^ mchip(mb, 4))) hits++;
            if (j % 2 == 1) ma = mstep(ma, 16'd12, 4);
            if (j % 3 == 2) mb = mstep(mb, 16'd12, 4);
            @(negedge clk);
        end
        chk(miss == 0, "R7 sync every 90 cycles", miss, 0);
        chk(hits == 0, "R10 R9 ref product", hits, 0);

        // zero-state recovery, R5
        configure(4, 0, 0, 1, 1, 15);
        miss = 0;
        for (int j = 0; j < 20; j++) begin
            if (sync_out != (j % 4 == 0)) miss++;
            @(negedge clk);
        end
        chk(miss == 0, "R5 zero avoided, sync every 4", miss, 0);

        // switch to transmit mid-run, R1
        configure(4, 12, 12, 1, 2, 3);
        repeat (5) @(negedge clk);
        mode_rx = 1'b0;
        @(negedge clk);
        @(negedge clk);
        miss = 0;
        for (int j = 0; j < 60; j++) begin
            if (sync_out || ref_out || corr_valid) miss++;
            @(negedge clk);
        end
        chk(miss == 0, "R1 tx after rx idle", miss, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule